// File: doc/BRIEF.md
# Separate-Port Burst-of-Four SRAM Core

This block is a synthesizable behavioural model of a synchronous static RAM that has one port for reads and a separate port for writes. Its purpose is to stand in for an external burst memory during on-chip emulation, and to act as a target when verifying a memory controller. Every accepted request moves exactly four data words. The request address names a four-word group. The two low word-address bits are not carried on the request; the core steps them through 0, 1, 2 and 3, one beat per clock. Double-data-rate pad timing is abstracted away: each beat takes one clock and carries a beat index.

A write request carries its first data beat and that beat's byte enables in the same cycle. The other three beats follow on the next three cycles, each beat with its own byte enables. A read request returns four beats after a parameterized latency, each flagged valid and tagged with its beat index. A read and a write may be issued in the same cycle. A read always returns the data of every write accepted in the same cycle or earlier, even when part of that write is still arriving or has not yet been committed to the array. A request that arrives while a burst of the same kind is still running is dropped, and an error flag is raised.

Top module: `quad_burst_sram`

## Requirements
- R1: Each accepted read produces exactly four output cycles with `rd_valid` high on consecutive cycles. `rd_beat` carries 0, 1, 2, 3 in order, and no output beat appears without a request.
- R2: Beat k of a burst with request address A belongs to word address A*4+k: A supplies the upper bits and k supplies the two lowest bits.
- R3: If a read request is sampled in cycle r, beat k is presented in cycle r+RD_LAT+k. RD_LAT defaults to 2 and must be at least 2.
- R4: An accepted write takes beat 0 data and enables from the request cycle and beats 1, 2 and 3 from the three cycles that follow. `wr_data` and `wr_be` have no effect in any other cycle.
- R5: The data word has LANES lanes of LANE_W bits; lane i is bits [i*LANE_W+LANE_W-1 : i*LANE_W]. `wr_be[i]`=1 on a beat writes lane i of that beat's word, and `wr_be[i]`=0 leaves the old lane contents in place.
- R6: A read request and a write request in the same cycle are both accepted.
- R7: A read sees every write accepted in its request cycle or earlier, merged lane by lane, including writes whose beats are still arriving. It sees no write accepted after its request cycle.
- R8: A read request in any of the three cycles after an accepted read is ignored, and so is a write request in any of the three cycles after an accepted write. In each case `proto_err` is high in the following cycle and low otherwise. An ignored write changes no memory content.
- R9: After reset `rd_valid` and `proto_err` are low and `rd_beat` is 0.
- R10: A new request of the same kind is accepted exactly four cycles after the previous one, and back-to-back reads give eight consecutive valid beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Read burst request |
| rd_addr | input | ADDR_W | Four-word group address of the read |
| wr_req | input | 1 | Write burst request, qualifying beat 0 |
| wr_addr | input | ADDR_W | Four-word group address of the write |
| wr_data | input | LANE_W*LANES | Write data of the current beat |
| wr_be | input | LANES | Active-high lane enables of the current beat |
| rd_valid | output | 1 | A read beat is present |
| rd_beat | output | 2 | Index of the present read beat |
| rd_data | output | LANE_W*LANES | Read data of the present beat |
| proto_err | output | 1 | Previous cycle held an ignored request |

## Verification
The embedded assertions check on every cycle that read beats come out in order and that each output burst starts at index zero. They also check that the write collection buffer fills one beat per cycle, that an ignored request leaves the captured burst address untouched, and that the commit stage is never overwritten before it has drained. Only the bench scenarios can show that the data values are correct. These scenarios compare against a reference array and cover the exact latency, byte-lane merging, and forwarding from a write that is still arriving or waiting to commit. They also show that a read issued one cycle before a write does not see it, and that an ignored write leaves memory unchanged.

// File: rtl/qb_pkg.sv
// Package: shared constants and beat index type for the burst-of-four core.
package qb_pkg;
    localparam int BEATS  = 4;
    localparam int BEAT_W = 2;
    typedef logic [BEAT_W-1:0] beat_t;
    localparam beat_t LAST_BEAT = beat_t'(BEATS - 1);
endpackage

// File: rtl/qb_wr_collect.sv
// Write collector: accepts a write burst and gathers its four beats, each with
// its own lane enables, into a collection buffer. When the last beat arrives it
// moves the whole burst into a one-entry commit stage, which writes the array in
// the next cycle. Assumes the requester keeps beats on consecutive cycles.
module qb_wr_collect #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       wr_req,
    input  logic [ADDR_W-1:0]                          wr_addr,
    input  logic [DATA_W-1:0]                          wr_data,
    input  logic [LANES-1:0]                           wr_be,
    output logic                                       wr_reject,
    output logic [ADDR_W-1:0]                          col_base,
    output logic [qb_pkg::BEATS-1:0]                   col_vld,
    output logic [qb_pkg::BEATS-1:0][DATA_W-1:0]       col_data,
    output logic [qb_pkg::BEATS-1:0][LANES-1:0]        col_be,
    output logic                                       cmt_vld,
    output logic [ADDR_W-1:0]                          cmt_base,
    output logic [qb_pkg::BEATS-1:0][DATA_W-1:0]       cmt_data,
    output logic [qb_pkg::BEATS-1:0][LANES-1:0]        cmt_be
);
    import qb_pkg::*;

    logic  wact;
    beat_t wbeat;
    logic  wr_accept;
    logic  beat_live;
    beat_t beat_idx;
    logic  push;

    // Decode acceptance, rejection and the index of the beat on the bus.
    always_comb begin
        wr_accept = wr_req && !wact;
        wr_reject = wr_req && wact;
        beat_live = wr_accept || wact;
        beat_idx  = wr_accept ? beat_t'(0) : wbeat;
        push      = wact && (wbeat == LAST_BEAT);
    end

    // Burst sequencer: counts beats 1..3 after an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wact  <= 1'b0;
            wbeat <= '0;
        end else if (wr_accept) begin
            wact  <= 1'b1;
            wbeat <= beat_t'(1);
        end else if (wact) begin
            if (wbeat == LAST_BEAT) wact <= 1'b0;
            wbeat <= wbeat + beat_t'(1);
        end
    end

    // Collection buffer control: base address and per-beat valid bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_base <= '0;
            col_vld  <= '0;
        end else if (wr_accept) begin
            col_base <= wr_addr;
            col_vld  <= BEATS'(1);
        end else if (wact) begin
            if (wbeat == LAST_BEAT) col_vld <= '0;
            else                    col_vld[wbeat] <= 1'b1;
        end
    end

    // Collection buffer payload: data and lane enables of each live beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_data <= '0;
            col_be   <= '0;
        end else if (beat_live) begin
            col_data[beat_idx] <= wr_data;
            col_be[beat_idx]   <= wr_be;
        end
    end

    // Commit stage: holds a completed burst for the single array write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmt_vld  <= 1'b0;
            cmt_base <= '0;
            cmt_data <= '0;
            cmt_be   <= '0;
        end else begin
            cmt_vld <= push;
            if (push) begin
                cmt_base <= col_base;
                for (int b = 0; b < BEATS; b++) begin
                    cmt_data[b] <= (b == BEATS - 1) ? wr_data : col_data[b];
                    cmt_be[b]   <= (b == BEATS - 1) ? wr_be   : col_be[b];
                end
            end
        end
    end

    // The buffer fills one beat per cycle while a burst is running.
    assert_collect_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wact |-> ($countones(col_vld) == int'(wbeat)));

    // Beat counter advances by one each cycle of a running burst.
    assert_beat_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wact && wbeat != LAST_BEAT) |=> (wact && wbeat == beat_t'($past(wbeat) + beat_t'(1))));

    // An ignored request never disturbs the burst being collected.
    assert_reject_keeps_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |=> $stable(col_base));

    // A completed burst never lands on a commit stage that still holds data.
    assert_no_commit_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !cmt_vld);
endmodule

// File: rtl/qb_bank_array.sv
// Storage array split into one bank per beat index, so that a whole burst is
// committed in a single cycle. Lane enables gate each bank's write per lane.
// Read is asynchronous for one beat of one group; contents are not reset.
module qb_bank_array #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DATA_W = LANE_W * LANES,
    localparam int DEPTH  = 2 ** ADDR_W
) (
    input  logic                                  clk,
    input  logic                                  we,
    input  logic [ADDR_W-1:0]                     wbase,
    input  logic [qb_pkg::BEATS-1:0][DATA_W-1:0]  wdata,
    input  logic [qb_pkg::BEATS-1:0][LANES-1:0]   wbe,
    input  logic [ADDR_W-1:0]                     rbase,
    input  qb_pkg::beat_t                         rbeat,
    output logic [DATA_W-1:0]                     rdata
);
    import qb_pkg::*;

    logic [BEATS-1:0][DATA_W-1:0] bank_q;

    for (genvar b = 0; b < BEATS; b++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];

        // Bank write: store enabled lanes of this bank's beat.
        always_ff @(posedge clk) begin
            if (we) begin
                for (int l = 0; l < LANES; l++) begin
                    if (wbe[b][l]) mem[wbase][l*LANE_W +: LANE_W] <= wdata[b][l*LANE_W +: LANE_W];
                end
            end
        end

        assign bank_q[b] = mem[rbase];
    end

    assign rdata = bank_q[rbeat];
endmodule

// File: rtl/qb_rd_path.sv
// Read path: accepts a read burst and resolves one beat per cycle in the cycle
// after the request. Each beat merges, lane by lane, the array word, then the
// commit stage and then the collection buffer, the newest data taking priority.
// The resolved beat passes through RD_LAT-1 register stages to the outputs.
// Assumes RD_LAT >= 2.
module qb_rd_path #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int RD_LAT = 2,
    localparam int DATA_W = LANE_W * LANES,
    localparam int STAGES = RD_LAT - 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  rd_req,
    input  logic [ADDR_W-1:0]                     rd_addr,
    input  logic [ADDR_W-1:0]                     col_base,
    input  logic [qb_pkg::BEATS-1:0]              col_vld,
    input  logic [qb_pkg::BEATS-1:0][DATA_W-1:0]  col_data,
    input  logic [qb_pkg::BEATS-1:0][LANES-1:0]   col_be,
    input  logic                                  cmt_vld,
    input  logic [ADDR_W-1:0]                     cmt_base,
    input  logic [qb_pkg::BEATS-1:0][DATA_W-1:0]  cmt_data,
    input  logic [qb_pkg::BEATS-1:0][LANES-1:0]   cmt_be,
    input  logic [DATA_W-1:0]                     arr_q,
    output logic [ADDR_W-1:0]                     arr_base,
    output qb_pkg::beat_t                         arr_beat,
    output logic                                  rd_reject,
    output logic                                  rd_valid,
    output qb_pkg::beat_t                         rd_beat,
    output logic [DATA_W-1:0]                     rd_data
);
    import qb_pkg::*;

    logic              ract;
    beat_t             rbeat;
    logic [ADDR_W-1:0] rbase;
    logic              rd_accept;
    logic [DATA_W-1:0] merged;

    logic [STAGES-1:0] pv;
    beat_t             pb [STAGES];
    logic [DATA_W-1:0] pd [STAGES];

    // Accept when idle or when the running burst resolves its last beat.
    always_comb begin
        rd_accept = rd_req && (!ract || rbeat == LAST_BEAT);
        rd_reject = rd_req && !rd_accept;
        arr_base  = rbase;
        arr_beat  = rbeat;
    end

    // Read sequencer: one resolved beat per cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ract  <= 1'b0;
            rbeat <= '0;
            rbase <= '0;
        end else if (rd_accept) begin
            ract  <= 1'b1;
            rbeat <= '0;
            rbase <= rd_addr;
        end else if (ract) begin
            if (rbeat == LAST_BEAT) ract <= 1'b0;
            rbeat <= rbeat + beat_t'(1);
        end
    end

    // Coherence merge: array, then commit stage, then collection buffer.
    always_comb begin
        merged = arr_q;
        if (cmt_vld && cmt_base == rbase) begin
            for (int l = 0; l < LANES; l++) begin
                if (cmt_be[rbeat][l]) merged[l*LANE_W +: LANE_W] = cmt_data[rbeat][l*LANE_W +: LANE_W];
            end
        end
        if (col_vld[rbeat] && col_base == rbase) begin
            for (int l = 0; l < LANES; l++) begin
                if (col_be[rbeat][l]) merged[l*LANE_W +: LANE_W] = col_data[rbeat][l*LANE_W +: LANE_W];
            end
        end
    end

    // Output pipeline: first stage captures the resolved beat, later stages delay it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                pv[s] <= 1'b0;
                pb[s] <= '0;
                pd[s] <= '0;
            end
        end else begin
            pv[0] <= ract;
            pb[0] <= ract ? rbeat : beat_t'(0);
            pd[0] <= merged;
            for (int s = 1; s < STAGES; s++) begin
                pv[s] <= pv[s-1];
                pb[s] <= pb[s-1];
                pd[s] <= pd[s-1];
            end
        end
    end

    assign rd_valid = pv[STAGES-1];
    assign rd_beat  = pb[STAGES-1];
    assign rd_data  = pd[STAGES-1];

    // Output beats run 0..3 on consecutive cycles.
    assert_beats_in_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_beat != LAST_BEAT) |=> (rd_valid && rd_beat == beat_t'($past(rd_beat) + beat_t'(1))));

    // A burst on the outputs always begins with beat zero.
    assert_burst_starts_at_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> (rd_beat == beat_t'(0)));

    // An ignored read never moves the running burst's address.
    assert_reject_keeps_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_reject |=> $stable(rbase));
endmodule

// File: rtl/quad_burst_sram.sv
// Top of the separate-port burst-of-four SRAM core. Ties the write collector,
// the per-beat bank array and the coherent read path together, and registers
// the protocol error flag. Assumes RD_LAT >= 2.
module quad_burst_sram #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int RD_LAT = 2,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    output logic              rd_valid,
    output logic [1:0]        rd_beat,
    output logic [DATA_W-1:0] rd_data,
    output logic              proto_err
);
    import qb_pkg::*;

    logic                         wr_reject;
    logic                         rd_reject;
    logic [ADDR_W-1:0]            col_base;
    logic [BEATS-1:0]             col_vld;
    logic [BEATS-1:0][DATA_W-1:0] col_data;
    logic [BEATS-1:0][LANES-1:0]  col_be;
    logic                         cmt_vld;
    logic [ADDR_W-1:0]            cmt_base;
    logic [BEATS-1:0][DATA_W-1:0] cmt_data;
    logic [BEATS-1:0][LANES-1:0]  cmt_be;
    logic [ADDR_W-1:0]            arr_base;
    beat_t                        arr_beat;
    logic [DATA_W-1:0]            arr_q;
    beat_t                        out_beat;

    qb_wr_collect #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .wr_reject(wr_reject),
        .col_base(col_base), .col_vld(col_vld), .col_data(col_data), .col_be(col_be),
        .cmt_vld(cmt_vld), .cmt_base(cmt_base), .cmt_data(cmt_data), .cmt_be(cmt_be)
    );

    qb_bank_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
        .clk(clk), .we(cmt_vld), .wbase(cmt_base), .wdata(cmt_data), .wbe(cmt_be),
        .rbase(arr_base), .rbeat(arr_beat), .rdata(arr_q)
    );

    qb_rd_path #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES), .RD_LAT(RD_LAT)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .col_base(col_base), .col_vld(col_vld), .col_data(col_data), .col_be(col_be),
        .cmt_vld(cmt_vld), .cmt_base(cmt_base), .cmt_data(cmt_data), .cmt_be(cmt_be),
        .arr_q(arr_q), .arr_base(arr_base), .arr_beat(arr_beat),
        .rd_reject(rd_reject), .rd_valid(rd_valid), .rd_beat(out_beat), .rd_data(rd_data)
    );

    assign rd_beat = out_beat;

    // Error flag: one cycle after any ignored request.
    always_ff @(posedge clk) begin
        if (!rst_n) proto_err <= 1'b0;
        else        proto_err <= rd_reject | wr_reject;
    end

    // The flag rises only after a request was actually presented.
    assert_err_needs_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err) |-> $past(rd_req || wr_req));
endmodule

// File: tb/quad_burst_sram_bench.sv
`timescale 1ns/1ps
module quad_burst_sram_bench;
    localparam int AW  = 6;
    localparam int LW  = 9;
    localparam int NL  = 2;
    localparam int DW  = LW * NL;
    localparam int LAT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req, wr_req;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] wr_data;
    logic [NL-1:0] wr_be;
    logic          rd_valid;
    logic [1:0]    rd_beat;
    logic [DW-1:0] rd_data;
    logic          proto_err;

    always #2 clk = ~clk;

    quad_burst_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL), .RD_LAT(LAT)) u_quad_burst_sram (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .rd_valid(rd_valid), .rd_beat(rd_beat), .rd_data(rd_data), .proto_err(proto_err)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { logic [DW-1:0] d; logic [1:0] b; int c; } exp_t;
    exp_t sbq[$];

    logic [DW-1:0] ref_mem [4 * (2 ** AW)];

    // scheduled requests for the next tick
    logic                q_wr = 0, q_wr_acc = 0, q_rd = 0, q_rd_acc = 0;
    logic [AW-1:0]       q_waddr = '0, q_raddr = '0;
    logic [3:0][DW-1:0]  q_d = '0;
    logic [3:0][NL-1:0]  q_be = '0;
    // write burst being driven
    logic [3:0][DW-1:0]  cur_d = '0;
    logic [3:0][NL-1:0]  cur_be = '0;
    int                  widx = 4;
    logic                exp_err = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic sched_write(input logic [AW-1:0] a, input logic acc,
                               input logic [3:0][DW-1:0] d, input logic [3:0][NL-1:0] be);
        q_wr = 1'b1; q_wr_acc = acc; q_waddr = a; q_d = d; q_be = be;
    endtask

    task automatic sched_read(input logic [AW-1:0] a, input logic acc);
        q_rd = 1'b1; q_rd_acc = acc; q_raddr = a;
    endtask

    function automatic logic [3:0][DW-1:0] rnd4();
        logic [3:0][DW-1:0] r;
        for (int k = 0; k < 4; k++) r[k] = DW'($urandom);
        return r;
    endfunction

    // Driver: one cycle of stimulus; pushes expected read beats to the scoreboard.
    task automatic tick();
        @(negedge clk);
        chk(proto_err === exp_err, "R8 proto_err", 32'(proto_err), 32'(exp_err));
        wr_req  = 1'b0;
        rd_req  = 1'b0;
        wr_data = DW'($urandom);   // outside a burst: must be ignored (R4)
        wr_be   = '1;
        wr_addr = AW'($urandom);
        rd_addr = AW'($urandom);
        if (widx < 4) begin
            wr_data = cur_d[widx];
            wr_be   = cur_be[widx];
            widx++;
        end
        if (q_wr) begin
            wr_req  = 1'b1;
            wr_addr = q_waddr;
            if (q_wr_acc) begin
                cur_d = q_d; cur_be = q_be; widx = 1;
                wr_data = q_d[0]; wr_be = q_be[0];
                for (int k = 0; k < 4; k++)
                    for (int l = 0; l < NL; l++)
                        if (q_be[k][l]) ref_mem[{q_waddr, 2'(k)}][l*LW +: LW] = q_d[k][l*LW +: LW];
            end
        end
        if (q_rd) begin
            rd_req  = 1'b1;
            rd_addr = q_raddr;
            if (q_rd_acc)
                for (int k = 0; k < 4; k++) begin
                    exp_t e;
                    e.d = ref_mem[{q_raddr, 2'(k)}];
                    e.b = 2'(k);
                    e.c = cyc + LAT + k;
                    sbq.push_back(e);
                end
        end
        exp_err = (q_wr && !q_wr_acc) || (q_rd && !q_rd_acc);
        q_wr = 1'b0;
        q_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Monitor: pops the scoreboard as read beats appear.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R1/R8 unexpected read beat", 32'(rd_beat), 32'hFFFF);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(rd_data === e.d, "R2/R5/R7 read data", 32'(rd_data), 32'(e.d));
                    chk(rd_beat === e.b, "R1 beat index", 32'(rd_beat), 32'(e.b));
                    chk(cyc == e.c, "R3/R10 beat cycle", 32'(cyc), 32'(e.c));
                end
            end else if (sbq.size() != 0 && sbq[0].c <= cyc) begin
                chk(1'b0, "R1/R3 missing read beat", 32'(cyc), 32'(sbq[0].c));
                void'(sbq.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rd_req = 0; wr_req = 0; rd_addr = '0; wr_addr = '0; wr_data = '0; wr_be = '0;
        repeat (4) @(negedge clk);
        // R9: reset state
        chk(rd_valid === 1'b0, "R9 rd_valid", 32'(rd_valid), 0);
        chk(rd_beat === 2'd0, "R9 rd_beat", 32'(rd_beat), 0);
        chk(proto_err === 1'b0, "R9 proto_err", 32'(proto_err), 0);
        rst_n = 1'b1;

        // preload every group with full-lane writes (R4, R10 spacing)
        for (int a = 0; a < 2 ** AW; a++) begin
            sched_write(AW'(a), 1'b1, rnd4(), '1);
            tick(); idle(3);
        end

        // R1 R2 R3 R10: back-to-back reads
        sched_read(6'd5, 1'b1); tick(); idle(3);
        sched_read(6'd6, 1'b1); tick(); idle(7);

        // R5: partial lane writes, lane 0 = bits 8:0, lane 1 = bits 17:9
        sched_write(6'd9, 1'b1, rnd4(), {2'b01, 2'b10, 2'b00, 2'b11}); tick(); idle(7);
        sched_read(6'd9, 1'b1); tick(); idle(7);

        // R6 R7: read and write of the same group in the same cycle
        sched_write(6'd12, 1'b1, rnd4(), '1); sched_read(6'd12, 1'b1); tick(); idle(7);

        // R7: read one cycle before the write sees old data
        sched_read(6'd14, 1'b1); tick();
        sched_write(6'd14, 1'b1, rnd4(), '1); tick(); idle(8);

        // R7: read while the write is still arriving
        sched_write(6'd15, 1'b1, rnd4(), {2'b10, 2'b11, 2'b01, 2'b10}); tick(); tick();
        sched_read(6'd15, 1'b1); tick(); idle(8);

        // R7: commit stage and collection buffer both hold the group
        sched_write(6'd20, 1'b1, rnd4(), '1); tick(); idle(3);
        sched_write(6'd20, 1'b1, rnd4(), {2'b01, 2'b00, 2'b10, 2'b01}); sched_read(6'd20, 1'b1); tick(); idle(8);

        // R8: read during a running read is ignored
        sched_read(6'd22, 1'b1); tick(); tick();
        sched_read(6'd23, 1'b0); tick(); idle(8);

        // R8: write during a running write is ignored, memory unchanged
        sched_write(6'd24, 1'b1, rnd4(), '1); tick();
        sched_write(6'd25, 1'b0, rnd4(), '1); tick(); idle(6);
        sched_read(6'd25, 1'b1); tick(); idle(3);
        sched_read(6'd24, 1'b1); tick(); idle(7);

        // R6 R10: streaming reads and writes in parallel
        for (int i = 0; i < 6; i++) begin
            sched_write(AW'(30 + i), 1'b1, rnd4(), NL'($urandom) == 0 ? '1 : {4{NL'($urandom)}});
            sched_read(AW'(40 + i), 1'b1);
            tick(); idle(3);
        end
        idle(6);

        // R5 R7: random overlap on a few groups
        for (int it = 0; it < 40; it++) begin
            int o;
            o = $urandom_range(0, 3);
            sched_write(AW'($urandom_range(0, 3)), 1'b1, rnd4(),
                        {NL'($urandom), NL'($urandom), NL'($urandom), NL'($urandom)});
            for (int t = 0; t < 8; t++) begin
                if (t == o) sched_read(AW'($urandom_range(0, 3)), 1'b1);
                tick();
            end
        end
        idle(10);
        chk(sbq.size() == 0, "R1 all expected beats delivered", 32'(sbq.size()), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule